// File: doc/BRIEF.md
# Tearing-Effect Sync Trigger

This block watches the tearing-effect signalling that an external display controller sends back to the host. It decides when a pending frame transfer may begin. The controller either drives two separate lines, one for line (horizontal) sync and one for frame (vertical) sync, or drives a single line. On a single line the two kinds of sync are told apart by how long each pulse lasts. Both lines pass through a synchronizer, and the block measures how long each pulse stays active. From those events it keeps a count of lines since the last frame sync.

Software programs the following:
- the minimum width, in clock ticks, of a line pulse and of a frame pulse;
- the active level of each input;
- the operating mode;
- a target line.

It then raises a transfer request. When the line count reaches the target, the block releases that request as a one-cycle start pulse. With sync switched off, a request starts the transfer on the next cycle without waiting. The pulse that does this is an internal trigger that clears itself.

Top module: `te_sync_trigger`

## Requirements
- R1: After reset `xfer_go` is low, no request is pending, and the line count is 0.
- R2: With `cfg_mode` equal to 0 or 3 (sync off), `xfer_go` is high in the cycle after each cycle in which `xfer_req` is sampled high, and pulses on `te_h` and `te_v` never cause `xfer_go`.
- R3: Each input passes its polarity bit first: a set bit means active-high and a clear bit means active-low. It then passes a two-flop synchronizer. `te_h` uses `cfg_hs_pol` and `te_v` uses `cfg_vs_pol`.
- R4: In single-pin mode (`cfg_mode` = 1), a pulse on `te_h` that stays active for at least `cfg_vs_width` sampled cycles counts as a frame sync.
- R5: In single-pin mode, a pulse on `te_h` that lasts at least `cfg_hs_width` cycles but fewer than `cfg_vs_width` cycles counts as a line sync. A shorter pulse is ignored.
- R6: In two-pin mode (`cfg_mode` = 2), a pulse on `te_h` of at least `cfg_hs_width` cycles is a line sync and a pulse on `te_v` of at least `cfg_vs_width` cycles is a frame sync. Shorter pulses are ignored. In single-pin mode `te_v` is ignored.
- R7: A frame sync sets the line count to 0, and a line sync adds one to it. The count saturates at 2^LINE_W-1 (2047 by default). When both kinds of sync end in the same cycle, the frame sync wins.
- R8: In single-pin or two-pin mode, a pending request is released as a one-cycle `xfer_go` when a sync event makes the line count equal to `cfg_line`. `xfer_go` rises on the second rising edge after the edge that first samples the pulse inactive.
- R9: In sync mode, a request stays pending across any number of non-matching events and is cleared when `xfer_go` fires. Without a pending request, a match gives no `xfer_go`. Turning sync off drops any pending request.
- R10: The pulse-width counter saturates at its maximum, so a pulse longer than 2^WIDTH_W-1 cycles still counts as a frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 off, 1 single-pin, 2 two-pin, 3 off |
| cfg_hs_width | input | WIDTH_W | Minimum line-sync pulse width in cycles |
| cfg_vs_width | input | WIDTH_W | Minimum frame-sync pulse width in cycles |
| cfg_hs_pol | input | 1 | `te_h` active level (1 = high) |
| cfg_vs_pol | input | 1 | `te_v` active level (1 = high) |
| cfg_line | input | LINE_W | Target line count |
| te_h | input | 1 | Line sync, or combined sync in single-pin mode |
| te_v | input | 1 | Frame sync in two-pin mode |
| xfer_req | input | 1 | Request a frame transfer start |
| xfer_go | output | 1 | One-cycle transfer start trigger |

## Verification
With sync off, `xfer_go` is due one cycle after `xfer_req` is sampled. In sync mode it is due on the second edge after the edge that first sees a pulse inactive again. That edge comes after two synchronizer flops, the width counter and the registered event and trigger stage. Every pulse the bench sends is followed by checks at the falling edge of each of the next four cycles: `xfer_go` must be low for two cycles, equal the expected value in the third, and be low again in the fourth. This timing is checked as well as the result. The expected result is derived from the pulse width against the thresholds and from the bench's own tally of the line count.

// File: rtl/te_sync_pkg.sv
package te_sync_pkg;

  typedef enum logic [1:0] {
    TE_MODE_OFF    = 2'd0,
    TE_MODE_SINGLE = 2'd1,
    TE_MODE_DUAL   = 2'd2,
    TE_MODE_RSVD   = 2'd3
  } te_mode_e;

  typedef struct packed {
    logic vsync;
    logic hsync;
  } te_event_t;

  // sync-derived triggering only in the two defined pin modes
  function automatic logic te_mode_active(te_mode_e m);
    return (m == TE_MODE_SINGLE) || (m == TE_MODE_DUAL);
  endfunction

endpackage

// File: rtl/te_sync_in.sv
module te_sync_in #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic active_high,
  output logic active
);
  logic [STAGES-1:0] chain_q;
  logic              level;

  // polarity applied ahead of the flops so a polarity change together
  // with an idle-level change never looks like a pulse
  assign level = active_high ? pin : ~pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], level};
  end

  assign active = chain_q[STAGES-1];
endmodule

// File: rtl/te_pulse_meter.sv
module te_pulse_meter #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  output logic               done,
  output logic [WIDTH_W-1:0] len
);
  logic [WIDTH_W-1:0] len_q;

  function automatic logic [WIDTH_W-1:0] sat_inc(logic [WIDTH_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (active) len_q <= sat_inc(len_q);
    else             len_q <= '0;
  end

  // pulse has just ended: input idle, length of the pulse still held
  assign done = !active && (len_q != '0);
  assign len  = len_q;
endmodule

// File: rtl/te_event_sort.sv
module te_event_sort
  import te_sync_pkg::*;
#(
  parameter int WIDTH_W = 8
) (
  input  te_mode_e           mode,
  input  logic               done_h,
  input  logic               done_v,
  input  logic [WIDTH_W-1:0] len_h,
  input  logic [WIDTH_W-1:0] len_v,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  output te_event_t          evt
);
  function automatic te_event_t classify(
    te_mode_e m, logic dh, logic dv,
    logic [WIDTH_W-1:0] lh, logic [WIDTH_W-1:0] lv,
    logic [WIDTH_W-1:0] hw, logic [WIDTH_W-1:0] vw);
    te_event_t e;
    e = '0;
    case (m)
      TE_MODE_SINGLE: begin
        if (dh) begin
          if (lh >= vw)      e.vsync = 1'b1;
          else if (lh >= hw) e.hsync = 1'b1;
        end
      end
      TE_MODE_DUAL: begin
        e.hsync = dh && (lh >= hw);
        e.vsync = dv && (lv >= vw);
      end
      default: e = '0;
    endcase
    return e;
  endfunction

  assign evt = classify(mode, done_h, done_v, len_h, len_v, hs_width, vs_width);
endmodule

// File: rtl/te_line_trigger.sv
module te_line_trigger
  import te_sync_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_on,
  input  te_event_t         evt,
  input  logic [LINE_W-1:0] target,
  input  logic              req,
  output logic              hit,
  output logic [LINE_W-1:0] line_cnt,
  output logic              go
);
  logic [LINE_W-1:0] cnt_q, cnt_nxt;
  logic              pend_q, want;

  function automatic logic [LINE_W-1:0] next_line(logic [LINE_W-1:0] c, te_event_t e);
    if (e.vsync)      return '0;
    else if (e.hsync) return (&c) ? c : c + 1'b1;
    else              return c;
  endfunction

  assign cnt_nxt = next_line(cnt_q, evt);
  assign hit     = sync_on && (evt.vsync || evt.hsync) && (cnt_nxt == target);
  assign want    = pend_q || req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      go     <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (sync_on) begin
        go     <= hit && want;
        pend_q <= want && !hit;
      end else begin
        go     <= req;
        pend_q <= 1'b0;
      end
    end
  end

  assign line_cnt = cnt_q;
endmodule

// File: rtl/te_sync_trigger.sv
module te_sync_trigger
  import te_sync_pkg::*;
#(
  parameter int WIDTH_W     = 8,
  parameter int LINE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         cfg_mode,
  input  logic [WIDTH_W-1:0] cfg_hs_width,
  input  logic [WIDTH_W-1:0] cfg_vs_width,
  input  logic               cfg_hs_pol,
  input  logic               cfg_vs_pol,
  input  logic [LINE_W-1:0]  cfg_line,
  input  logic               te_h,
  input  logic               te_v,
  input  logic               xfer_req,
  output logic               xfer_go
);
  localparam int NCH = 2;

  te_mode_e           mode;
  logic [NCH-1:0]     pin_in, pin_pol, pin_act, pin_done;
  logic [WIDTH_W-1:0] pin_len [NCH];
  te_event_t          evt;
  logic               evt_vs, evt_hs, sync_on, line_hit;
  logic [LINE_W-1:0]  line_cnt;

  assign mode    = te_mode_e'(cfg_mode);
  assign pin_in  = {te_v, te_h};
  assign pin_pol = {cfg_vs_pol, cfg_hs_pol};

  // channel 0 = te_h, channel 1 = te_v
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    te_sync_in #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_in[ch]),
      .active_high(pin_pol[ch]), .active(pin_act[ch]));
    te_pulse_meter #(.WIDTH_W(WIDTH_W)) u_meter (
      .clk(clk), .rst_n(rst_n), .active(pin_act[ch]),
      .done(pin_done[ch]), .len(pin_len[ch]));
  end

  te_event_sort #(.WIDTH_W(WIDTH_W)) u_sort (
    .mode(mode), .done_h(pin_done[0]), .done_v(pin_done[1]),
    .len_h(pin_len[0]), .len_v(pin_len[1]),
    .hs_width(cfg_hs_width), .vs_width(cfg_vs_width), .evt(evt));

  assign evt_vs  = evt.vsync;
  assign evt_hs  = evt.hsync;
  assign sync_on = te_mode_active(mode);

  te_line_trigger #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .sync_on(sync_on), .evt(evt),
    .target(cfg_line), .req(xfer_req), .hit(line_hit),
    .line_cnt(line_cnt), .go(xfer_go));
endmodule

// File: rtl/te_sync_trigger_chk.sv
module te_sync_trigger_chk #(
  parameter int LW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_mode,
  input logic [LW-1:0] cfg_line,
  input logic          xfer_req,
  input logic          xfer_go,
  input logic          evt_vs,
  input logic          evt_hs,
  input logic [LW-1:0] line_cnt
);
  logic seen_q, off_now, sync_now;

  assign off_now  = (cfg_mode == 2'd0) || (cfg_mode == 2'd3);
  assign sync_now = !off_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  AST_OFF_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && off_now && $past(off_now)) |-> (xfer_go == $past(xfer_req))); // R2

  AST_SINGLE_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1) |-> !(evt_vs && evt_hs)); // R4

  AST_VS_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vs |=> (line_cnt == '0)); // R7

  AST_HS_STEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hs && !evt_vs && !(&line_cnt)) |=> (line_cnt == $past(line_cnt) + 1'b1)); // R7

  AST_GO_AT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(sync_now) && xfer_go) |-> (line_cnt == $past(cfg_line))); // R8

  AST_GO_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(sync_now) && xfer_go) |-> $past(evt_vs || evt_hs)); // R8
endmodule

bind te_sync_trigger te_sync_trigger_chk #(.LW(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_line(cfg_line),
  .xfer_req(xfer_req), .xfer_go(xfer_go), .evt_vs(evt_vs), .evt_hs(evt_hs),
  .line_cnt(line_cnt));

// File: tb/te_sync_trigger_bench.sv
module te_sync_trigger_bench;
  localparam int WW = 8;
  localparam int LW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [WW-1:0] hs_w = 8'd3, vs_w = 8'd6;
  logic          hs_pol = 1'b1, vs_pol = 1'b1;
  logic [LW-1:0] target = '0;
  logic          te_h = 1'b0, te_v = 1'b0, req = 1'b0;
  logic          xfer_go;

  int vectors = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  te_sync_trigger #(.WIDTH_W(WW), .LINE_W(LW), .SYNC_STAGES(2)) u_te_sync_trigger (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_hs_width(hs_w),
    .cfg_vs_width(vs_w), .cfg_hs_pol(hs_pol), .cfg_vs_pol(vs_pol),
    .cfg_line(target), .te_h(te_h), .te_v(te_v), .xfer_req(req),
    .xfer_go(xfer_go));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_pins(input bit a_h, input bit a_v);
    te_h = a_h ? hs_pol : ~hs_pol;
    te_v = a_v ? vs_pol : ~vs_pol;
  endtask

  // which: 0 = te_h, 1 = te_v, 2 = both
  task automatic pulse_raw(input int which, input int n);
    @(negedge clk);
    set_pins(which != 1, which != 0);
    repeat (n) @(negedge clk);
    set_pins(0, 0);
  endtask

  task automatic pulse_chk(input int which, input int n, input bit exp, input string tag);
    pulse_raw(which, n);
    repeat (2) begin
      @(negedge clk);
      check(xfer_go == 1'b0, {tag, " early"}, xfer_go, 0);
    end
    @(negedge clk);
    check(xfer_go == exp, tag, xfer_go, exp);
    @(negedge clk);
    check(xfer_go == 1'b0, {tag, " one-cycle"}, xfer_go, 0);
  endtask

  task automatic do_req();
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic flush(input logic [1:0] m);
    @(negedge clk); mode = 2'd0;
    repeat (2) @(negedge clk);
    mode = m;
  endtask

  initial begin
    set_pins(0, 0);
    repeat (3) @(negedge clk);
    check(xfer_go == 1'b0, "R1 go low in reset", xfer_go, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(xfer_go == 1'b0, "R1 go low after reset", xfer_go, 0);

    // R1: count starts at 0, so one line sync reaches target 1
    mode = 2'd2; hs_w = 8'd2; vs_w = 8'd3; target = 11'd1;
    do_req();
    pulse_chk(0, 2, 1, "R1 first line from zero");

    // R2: sync off, internal trigger
    foreach (mode[i]) ; // no-op
    for (int m = 0; m < 4; m += 3) begin
      mode = 2'(m);
      @(negedge clk); req = 1'b1;
      @(negedge clk); req = 1'b0;
      check(xfer_go == 1'b1, "R2 go after req", xfer_go, 1);
      @(negedge clk);
      check(xfer_go == 1'b0, "R2 go self-clears", xfer_go, 0);
      @(negedge clk); req = 1'b1;
      repeat (3) begin
        @(negedge clk);
        check(xfer_go == 1'b1, "R2 held req", xfer_go, 1);
      end
      req = 1'b0;
      @(negedge clk);
      check(xfer_go == 1'b0, "R2 release", xfer_go, 0);
      target = '0;
      pulse_chk(1, 5, 0, "R2 pins ignored te_v");
      pulse_chk(0, 9, 0, "R2 pins ignored te_h");
    end

    // R4 R5: single-pin width sweep, hs_w=3 vs_w=6
    hs_w = 8'd3; vs_w = 8'd6;
    for (int n = 1; n <= 9; n++) begin
      target = 11'd1; flush(2'd1);
      pulse_chk(0, 8, 0, "R4 reference frame");
      do_req();
      pulse_chk(0, n, (n >= 3 && n < 6), $sformatf("R5 width %0d as line", n));
      target = 11'd0; flush(2'd1);
      pulse_chk(0, 8, 0, "R4 reference frame");
      pulse_chk(0, 4, 0, "R5 reference line");
      do_req();
      pulse_chk(0, n, (n >= 6), $sformatf("R4 width %0d as frame", n));
    end

    // R3: active-low te_h in single-pin mode
    @(negedge clk); hs_pol = 1'b0; set_pins(0, 0);
    target = 11'd1; flush(2'd1);
    pulse_chk(0, 8, 0, "R3 low-active frame");
    do_req();
    pulse_chk(0, 4, 1, "R3 low-active line");
    @(negedge clk); hs_pol = 1'b1; set_pins(0, 0);

    // R6: single-pin ignores te_v
    target = 11'd0; flush(2'd1);
    pulse_chk(0, 8, 0, "R6 frame");
    pulse_chk(0, 4, 0, "R6 line");
    do_req();
    pulse_chk(1, 8, 0, "R6 te_v ignored single");
    pulse_chk(0, 8, 1, "R6 frame after ignored te_v");

    // R6: two-pin thresholds, hs_w=3 vs_w=2, te_v active-low
    @(negedge clk); vs_pol = 1'b0; set_pins(0, 0);
    hs_w = 8'd3; vs_w = 8'd2; target = 11'd1; flush(2'd2);
    pulse_chk(1, 2, 0, "R6 dual frame");
    do_req();
    pulse_chk(0, 2, 0, "R6 dual short line ignored");
    pulse_chk(0, 3, 1, "R6 dual line");
    target = 11'd0; flush(2'd2);
    pulse_chk(1, 2, 0, "R6 dual frame");
    pulse_chk(0, 3, 0, "R6 dual line");
    do_req();
    pulse_chk(1, 1, 0, "R6 dual short frame ignored");
    pulse_chk(1, 2, 1, "R6 dual frame hits 0");
    @(negedge clk); vs_pol = 1'b1; set_pins(0, 0);

    // R8: target sweep, two-pin hs_w=2 vs_w=3
    hs_w = 8'd2; vs_w = 8'd3;
    for (int t = 0; t <= 6; t++) begin
      target = 11'(t); flush(2'd2);
      do_req();
      pulse_chk(1, 3, (t == 0), $sformatf("R8 target %0d frame", t));
      for (int k = 1; k <= 7; k++)
        pulse_chk(0, 2, (k == t), $sformatf("R8 target %0d line %0d", t, k));
    end

    // R9: no request, no trigger; one-shot; off drops pending
    target = 11'd2; flush(2'd2);
    pulse_chk(1, 3, 0, "R9 no req frame");
    pulse_chk(0, 2, 0, "R9 no req line1");
    pulse_chk(0, 2, 0, "R9 no req line2");
    target = 11'd0; do_req();
    pulse_chk(1, 3, 1, "R9 fires once");
    pulse_chk(1, 3, 0, "R9 cleared after go");
    target = 11'd1; do_req();
    flush(2'd2);
    pulse_chk(1, 3, 0, "R9 dropped frame");
    pulse_chk(0, 2, 0, "R9 dropped by off");

    // R7: frame wins over simultaneous line
    target = 11'd0; flush(2'd2);
    pulse_chk(1, 3, 0, "R7 frame");
    pulse_chk(0, 2, 0, "R7 line");
    do_req();
    pulse_chk(2, 3, 1, "R7 frame priority");

    // R7: saturation at 2047
    target = 11'd2047; flush(2'd2);
    pulse_raw(1, 3);
    repeat (2046) pulse_raw(0, 2);
    repeat (4) @(negedge clk);
    do_req();
    pulse_chk(0, 2, 1, "R7 reach 2047");
    do_req();
    pulse_chk(0, 2, 1, "R7 saturated at 2047");

    // R10: width counter saturation, 260 would wrap to 4 (line)
    hs_w = 8'd3; vs_w = 8'd6; target = 11'd1; flush(2'd1);
    pulse_chk(0, 8, 0, "R10 frame");
    do_req();
    pulse_chk(0, 260, 0, "R10 long pulse stays frame");
    pulse_chk(0, 4, 1, "R10 line after long frame");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule